// File: doc/BRIEF.md
# Battery Backup Mode Controller

This block decides whether the system output rail is fed from the main supply or from the backup battery. It also forces the supervisor's externally visible outputs to fixed states while the battery carries the load. Two digital flags come from the analog side. The first says the main supply is under the reset threshold. The second says the main supply is under the battery voltage. Comparator hysteresis is already applied to both flags before they reach this block.

Backup mode is entered only when both flags are high together. It is left on the first clock edge at which either flag is low. In backup mode the following overrides apply, and the normal-mode inputs for these outputs are ignored:

- The power-fail output is forced low.
- The low-line output and the active-low reset are forced low.
- The active-high reset output is released by dropping its output enable.
- The watchdog fault output and the gated chip-enable are forced high.

In main-supply mode these outputs follow the rest of the supervisor. The reset outputs depend only on the threshold flag and on the reset generator's request. The battery decision never changes them.

Every output is a register. All of them reflect, one clock later, the flags and inputs sampled at the preceding rising edge.

Top module: `bkup_mode_ctrl`

## Requirements
- R1: `rail_sel_batt` is 1 (battery feeds the rail) exactly when `below_thresh` and `below_batt` were both 1 at the previous rising edge; otherwise it is 0 (main supply).
- R2: `batt_on` is 1 while the rail is fed from the battery and 0 while it is fed from the main supply, always equal to `rail_sel_batt`.
- R3: In backup mode `pfail_n_out` is 0 whatever `pfail_n_in` is; in main mode `pfail_n_out` equals `pfail_n_in`.
- R4: In backup mode `lowline_n_out` is 0, `reset_n_out` is 0 and `reset_hi_oe` is 0 (active-high reset released).
- R5: In backup mode `wdog_n_out` and `ce_n_out` are 1 whatever `wdog_n_in` and `ce_n_in` are.
- R6: `reset_n_out` is 0 and `reset_hi_out` is 1 exactly when `below_thresh` or `rst_req` was 1; `below_batt` has no effect on either.
- R7: All outputs have one clock of latency, and the block returns to main mode at the first edge where either entry flag is 0.
- R8: In main mode `lowline_n_out` is the inverse of `below_thresh`, `reset_hi_oe` is 1, and `wdog_n_out` and `ce_n_out` equal `wdog_n_in` and `ce_n_in`.
- R9: While `rst` is high the outputs take: rail_sel_batt=0, batt_on=0, reset_n_out=0, reset_hi_out=1, reset_hi_oe=1, lowline_n_out=1, wdog_n_out=1, pfail_n_out=1, ce_n_out=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| below_thresh | input | 1 | Main supply under reset threshold |
| below_batt | input | 1 | Main supply under battery voltage |
| rst_req | input | 1 | Reset request from the reset generator (timeout or watchdog) |
| wdog_n_in | input | 1 | Normal-mode watchdog fault, active low |
| pfail_n_in | input | 1 | Normal-mode power-fail comparator result, active low |
| ce_n_in | input | 1 | Normal-mode gated chip-enable, active low |
| rail_sel_batt | output | 1 | Power switch select: 1 battery, 0 main |
| batt_on | output | 1 | Battery-on status |
| reset_n_out | output | 1 | Active-low reset |
| reset_hi_out | output | 1 | Active-high reset value |
| reset_hi_oe | output | 1 | Output enable of the active-high reset |
| lowline_n_out | output | 1 | Low-line indicator, active low |
| wdog_n_out | output | 1 | Watchdog fault output, active low |
| pfail_n_out | output | 1 | Power-fail output, active low |
| ce_n_out | output | 1 | Chip-enable output, active low |

## Verification
The assertions check on every cycle the following properties:

- Battery mode only follows a cycle in which both flags were high.
- The block leaves battery mode after a cycle in which either flag was low.
- The forced levels of the power-fail, low-line, reset, watchdog and chip-enable outputs hold throughout battery mode.
- The reset outputs track only the threshold flag and the reset request.

Only the bench scenarios show the rest:

- The pass-through values in main mode under mixed patterns.
- The reset-time output levels.
- Exit by each of the two flags separately.
- The fact that toggling the ignored inputs during battery mode leaves the outputs unchanged.

// File: rtl/bkup_pkg.sv
package bkup_pkg;
  typedef enum logic {
    MODE_MAIN = 1'b0,
    MODE_BATT = 1'b1
  } mode_e;

  typedef struct packed {
    logic reset_n;
    logic reset_hi;
    logic reset_hi_oe;
    logic lowline_n;
    logic wdog_n;
    logic pfail_n;
    logic ce_n;
  } sup_out_t;

  localparam sup_out_t SUP_OUT_RST = '{
    reset_n: 1'b0, reset_hi: 1'b1, reset_hi_oe: 1'b1,
    lowline_n: 1'b1, wdog_n: 1'b1, pfail_n: 1'b1, ce_n: 1'b1
  };
endpackage

// File: rtl/bkup_mode_fsm.sv
module bkup_mode_fsm
  import bkup_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  below_thresh,
  input  logic  below_batt,
  output mode_e mode_nxt,
  output mode_e mode_q
);
  // both conditions are needed to enter; losing either one leaves at once
  always_comb begin
    mode_nxt = (below_thresh && below_batt) ? MODE_BATT : MODE_MAIN;
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= MODE_MAIN;
    else     mode_q <= mode_nxt;
  end
endmodule

// File: rtl/bkup_out_ovr.sv
module bkup_out_ovr
  import bkup_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  mode_e    mode_nxt,
  input  logic     below_thresh,
  input  logic     rst_req,
  input  logic     wdog_n_in,
  input  logic     pfail_n_in,
  input  logic     ce_n_in,
  output sup_out_t out_q
);
  sup_out_t norm_val;
  sup_out_t batt_val;
  sup_out_t out_d;
  logic     rst_act;

  // reset depends on threshold and request only, never on the battery decision
  assign rst_act = below_thresh | rst_req;

  always_comb begin
    norm_val.reset_n     = ~rst_act;
    norm_val.reset_hi    = rst_act;
    norm_val.reset_hi_oe = 1'b1;
    norm_val.lowline_n   = ~below_thresh;
    norm_val.wdog_n      = wdog_n_in;
    norm_val.pfail_n     = pfail_n_in;
    norm_val.ce_n        = ce_n_in;
  end

  always_comb begin
    batt_val.reset_n     = 1'b0;
    batt_val.reset_hi    = rst_act;
    batt_val.reset_hi_oe = 1'b0;
    batt_val.lowline_n   = 1'b0;
    batt_val.wdog_n      = 1'b1;
    batt_val.pfail_n     = 1'b0;
    batt_val.ce_n        = 1'b1;
  end

  assign out_d = (mode_nxt == MODE_BATT) ? batt_val : norm_val;

  always_ff @(posedge clk) begin
    if (rst) out_q <= SUP_OUT_RST;
    else     out_q <= out_d;
  end
endmodule

// File: rtl/bkup_mode_ctrl.sv
module bkup_mode_ctrl
  import bkup_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic below_thresh,
  input  logic below_batt,
  input  logic rst_req,
  input  logic wdog_n_in,
  input  logic pfail_n_in,
  input  logic ce_n_in,
  output logic rail_sel_batt,
  output logic batt_on,
  output logic reset_n_out,
  output logic reset_hi_out,
  output logic reset_hi_oe,
  output logic lowline_n_out,
  output logic wdog_n_out,
  output logic pfail_n_out,
  output logic ce_n_out
);
  mode_e    mode_nxt;
  mode_e    mode_q;
  sup_out_t sup_q;

  bkup_mode_fsm u_fsm (
    .clk          (clk),
    .rst          (rst),
    .below_thresh (below_thresh),
    .below_batt   (below_batt),
    .mode_nxt     (mode_nxt),
    .mode_q       (mode_q)
  );

  bkup_out_ovr u_ovr (
    .clk          (clk),
    .rst          (rst),
    .mode_nxt     (mode_nxt),
    .below_thresh (below_thresh),
    .rst_req      (rst_req),
    .wdog_n_in    (wdog_n_in),
    .pfail_n_in   (pfail_n_in),
    .ce_n_in      (ce_n_in),
    .out_q        (sup_q)
  );

  assign rail_sel_batt = (mode_q == MODE_BATT);
  assign batt_on       = (mode_q == MODE_BATT);
  assign reset_n_out   = sup_q.reset_n;
  assign reset_hi_out  = sup_q.reset_hi;
  assign reset_hi_oe   = sup_q.reset_hi_oe;
  assign lowline_n_out = sup_q.lowline_n;
  assign wdog_n_out    = sup_q.wdog_n;
  assign pfail_n_out   = sup_q.pfail_n;
  assign ce_n_out      = sup_q.ce_n;
endmodule

// File: rtl/bkup_chk.sv
module bkup_chk (
  input logic clk,
  input logic rst,
  input logic below_thresh,
  input logic below_batt,
  input logic rst_req,
  input logic wdog_n_in,
  input logic pfail_n_in,
  input logic ce_n_in,
  input logic rail_sel_batt,
  input logic batt_on,
  input logic reset_n_out,
  input logic reset_hi_out,
  input logic reset_hi_oe,
  input logic lowline_n_out,
  input logic wdog_n_out,
  input logic pfail_n_out,
  input logic ce_n_out
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  p_entry_both_r1: assert property (@(posedge clk) disable iff (rst || !past_ok)
    rail_sel_batt |-> $past(below_thresh && below_batt));

  p_status_match_r2: assert property (@(posedge clk) disable iff (rst)
    batt_on == rail_sel_batt);

  p_pfail_forced_r3: assert property (@(posedge clk) disable iff (rst)
    batt_on |-> !pfail_n_out);

  p_backup_levels_r4: assert property (@(posedge clk) disable iff (rst)
    batt_on |-> (!lowline_n_out && !reset_n_out && !reset_hi_oe));

  p_backup_high_r5: assert property (@(posedge clk) disable iff (rst)
    batt_on |-> (wdog_n_out && ce_n_out));

  p_reset_source_r6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    (reset_n_out == !$past(below_thresh || rst_req)) && (reset_hi_out == !reset_n_out));

  p_exit_prompt_r7: assert property (@(posedge clk) disable iff (rst)
    !(below_thresh && below_batt) |=> !batt_on);
endmodule

bind bkup_mode_ctrl bkup_chk u_chk (.*);

// File: tb/sim_bkup_mode_ctrl.sv
module sim_bkup_mode_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic below_thresh = 1'b0, below_batt = 1'b0, rst_req = 1'b0;
  logic wdog_n_in = 1'b1, pfail_n_in = 1'b1, ce_n_in = 1'b1;
  logic rail_sel_batt, batt_on, reset_n_out, reset_hi_out, reset_hi_oe;
  logic lowline_n_out, wdog_n_out, pfail_n_out, ce_n_out;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  bkup_mode_ctrl u0 (.*);

  // {rail, batt, reset_n, reset_hi, oe, lowline_n, wdog_n, pfail_n, ce_n}
  function automatic logic [8:0] expect_out(input logic bt, bb, rq, wd, pf, ce);
    logic bk, ra;
    bk = bt & bb;
    ra = bt | rq;
    if (bk) expect_out = {1'b1, 1'b1, 1'b0, ra, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1};
    else    expect_out = {1'b0, 1'b0, ~ra, ra, 1'b1, ~bt, wd, pf, ce};
  endfunction

  task automatic chk(input string tag, input logic act, input logic expv);
    checks++;
    if (act !== expv) begin
      errors++;
      $display("FAIL %s act=%b exp=%b t=%0t", tag, act, expv, $time);
    end
  endtask

  task automatic step(input logic bt, bb, rq, wd, pf, ce);
    logic [8:0] e;
    below_thresh = bt; below_batt = bb; rst_req = rq;
    wdog_n_in = wd; pfail_n_in = pf; ce_n_in = ce;
    e = expect_out(bt, bb, rq, wd, pf, ce);
    @(posedge clk);
    @(negedge clk);
    chk("R1 rail_sel_batt", rail_sel_batt, e[8]);
    chk("R2 batt_on", batt_on, e[7]);
    chk("R6 reset_n_out", reset_n_out, e[6]);
    chk("R6 reset_hi_out", reset_hi_out, e[5]);
    chk("R4,R8 reset_hi_oe", reset_hi_oe, e[4]);
    chk("R4,R8 lowline_n_out", lowline_n_out, e[3]);
    chk("R5,R8 wdog_n_out", wdog_n_out, e[2]);
    chk("R3 pfail_n_out", pfail_n_out, e[1]);
    chk("R5,R8 ce_n_out", ce_n_out, e[0]);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset levels
    chk("R9 rail", rail_sel_batt, 1'b0);
    chk("R9 batt_on", batt_on, 1'b0);
    chk("R9 reset_n", reset_n_out, 1'b0);
    chk("R9 reset_hi", reset_hi_out, 1'b1);
    chk("R9 oe", reset_hi_oe, 1'b1);
    chk("R9 lowline", lowline_n_out, 1'b1);
    chk("R9 wdog", wdog_n_out, 1'b1);
    chk("R9 pfail", pfail_n_out, 1'b1);
    chk("R9 ce", ce_n_out, 1'b1);
    rst = 1'b0;

    // directed corners
    step(0, 0, 0, 1, 1, 0);   // R8 main pass-through
    step(0, 1, 0, 0, 0, 1);   // R6 below_batt alone: no reset, no backup
    step(1, 0, 0, 1, 0, 0);   // R1 threshold alone: reset, main
    step(1, 1, 0, 0, 1, 0);   // enter backup
    step(1, 1, 0, 1, 1, 1);   // R3 R5 ignored inputs toggled
    step(1, 1, 1, 0, 0, 0);
    step(1, 0, 0, 0, 1, 0);   // exit by battery flag
    chk("R7 exit on below_batt low", batt_on, 1'b0);
    step(1, 1, 0, 1, 1, 1);
    step(0, 1, 0, 1, 1, 0);   // exit by threshold flag
    chk("R7 exit on below_thresh low", batt_on, 1'b0);
    step(0, 0, 1, 1, 1, 1);   // R6 request alone

    // R7 latency: output keeps old value until the edge
    below_thresh = 1'b1; below_batt = 1'b1;
    #1;
    chk("R7 no change before edge", batt_on, 1'b0);
    step(1, 1, 0, 1, 1, 1);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] r;
      r = 6'($urandom);
      step(r[0], r[1], r[2] & r[3], r[4], r[5], r[3]);
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule